// File: doc/BRIEF.md
# Interrupt Status Controller with Atomic Set/Clear Registers

This block gathers one-cycle event pulses from the internal sources of a peripheral and turns them into a single level interrupt request. It holds three registers. The status register captures events. The enable register decides which captured events drive the request. The mask register decides which events are captured at all.

A masked event is discarded. It is not stored and cannot appear later when the mask bit is removed. An enable bit only gates the output, so status can still be polled for events that are not enabled. Enable and mask each have two write addresses, one that sets bits and one that clears bits. Software can therefore change single bits without a read-modify-write sequence. Status bits are cleared by writing ones to them.

A simple register-bus slave gives 32-bit write access and byte, halfword or word read access. Read data is registered and appears one clock after the read strobe.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After a synchronous reset, status, enable and mask are all zero, `irq_o` is low and `bus_rdata` is zero.
- R2: A write to the status address (byte offset 0x00) clears each status bit written as one and leaves the other bits unchanged.
- R3: A write to the enable-set address (0x04) ORs the write data into the enable register.
- R4: A write to the enable-clear address (0x08) clears each enable bit written as one and leaves the other bits unchanged.
- R5: The mask register behaves the same way, with its set address at 0x0C and its clear address at 0x10.
- R6: A high bit of `evt_i` at a clock edge sets the matching status bit only when the mask bit is zero. A masked event is lost, and clearing the mask afterwards does not make it appear.
- R7: `irq_o` is a register. After each clock edge it equals the OR over all bits of (status AND enable) as they stood before that edge. Enable has no effect on which events are latched.
- R8: A read returns the status value at 0x00, the enable value at both 0x04 and 0x08, and the mask value at both 0x0C and 0x10. The data is valid on `bus_rdata` after the clock edge that samples `bus_re`, and it holds until the next read.
- R9: If an event and a status clear write hit the same bit in the same cycle, the bit ends up set.
- R10: A read of size 0 (byte) or size 1 (halfword) returns the register word shifted right by 8 × (address mod 4), with the upper bits masked to 8 or 16 bits. Sizes 2 and 3 return the full shifted word. Writes always act on the whole 32-bit word selected by address bits above bit 1.
- R11: A read of any other word address returns zero, and a write to any other word address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Read size: 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_i | input | NUM_SRC | Event pulses, one bit per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps many mask, enable and event patterns and predicts status and the request line arithmetically.

Several specific faults are targeted:
- A design that latches masked events would show extra status bits.
- A design that gated latching with enable would lose status bits.
- A design that lets a same-cycle clear beat an event would drop the event bit.
- Wrong set/clear semantics would corrupt bits that were not written.

Reads of every byte offset at every size catch lane shifts in the wrong direction and a missing width mask. Writes to an unused address are checked against unchanged register values, which exposes loose address decoding.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_ENA_SET,
    SEL_ENA_CLR,
    SEL_MSK_SET,
    SEL_MSK_CLR
  } reg_sel_e;

  localparam int unsigned WIDX_STAT    = 0;
  localparam int unsigned WIDX_ENA_SET = 1;
  localparam int unsigned WIDX_ENA_CLR = 2;
  localparam int unsigned WIDX_MSK_SET = 3;
  localparam int unsigned WIDX_MSK_CLR = 4;

  function automatic reg_sel_e word_select(input int unsigned widx);
    case (widx)
      WIDX_STAT:    return SEL_STAT;
      WIDX_ENA_SET: return SEL_ENA_SET;
      WIDX_ENA_CLR: return SEL_ENA_CLR;
      WIDX_MSK_SET: return SEL_MSK_SET;
      WIDX_MSK_CLR: return SEL_MSK_CLR;
      default:      return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_bits) & ~clr_bits;
  end

  // R1
  reg_reset_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R3
  reg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we) |=> ((q & $past(wdata)) == $past(wdata)));

  // R4
  reg_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((q & $past(wdata)) == '0));

  // R11
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(q));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q
);

  logic [W-1:0] accepted;
  logic [W-1:0] clr_bits;

  assign accepted = evt & ~mask;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_bits) | accepted;
  end

  // R6
  stat_no_masked_set_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((status_q & ~$past(status_q) & ~$past(evt & ~mask)) == '0));

  // R9
  stat_evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt & ~mask) != '0) |=> ((status_q & $past(evt & ~mask)) == $past(evt & ~mask)));

  // R2
  stat_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status_q & $past(wdata & ~(evt & ~mask))) == '0));

  // R1
  stat_reset_chk: assert property (@(posedge clk) rst |=> (status_q == '0));

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] enable,
  input  logic [DATA_W-1:0] mask,
  output logic              stat_clr,
  output logic              ena_set,
  output logic              ena_clr,
  output logic              msk_set,
  output logic              msk_clr,
  output logic [DATA_W-1:0] rdata
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  reg_sel_e          sel;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] lane_mask;

  assign widx = bus_addr[ADDR_W-1:2];
  assign sel  = word_select(int'(widx));

  assign stat_clr = bus_we && (sel == SEL_STAT);
  assign ena_set  = bus_we && (sel == SEL_ENA_SET);
  assign ena_clr  = bus_we && (sel == SEL_ENA_CLR);
  assign msk_set  = bus_we && (sel == SEL_MSK_SET);
  assign msk_clr  = bus_we && (sel == SEL_MSK_CLR);

  always_comb begin
    case (sel)
      SEL_STAT:                 raw = status;
      SEL_ENA_SET, SEL_ENA_CLR: raw = enable;
      SEL_MSK_SET, SEL_MSK_CLR: raw = mask;
      default:                  raw = '0;
    endcase
  end

  assign shifted = raw >> {bus_addr[1:0], 3'b000};

  always_comb begin
    case (bus_size)
      2'd0:    lane_mask = DATA_W'(32'h0000_00FF);
      2'd1:    lane_mask = DATA_W'(32'h0000_FFFF);
      default: lane_mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_re) rdata <= shifted & lane_mask;
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(rdata));

  // R10
  rd_byte_width_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_size == 2'd0) |=> ((rdata & ~DATA_W'(32'hFF)) == '0));

  // R11
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stat_clr, ena_set, ena_clr, msk_set, msk_clr}));

endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl #(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o
);

  logic [DATA_W-1:0] evt_ext;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] mask_q;
  logic stat_clr, ena_set, ena_clr, msk_set, msk_clr;

  assign evt_ext = DATA_W'(evt_i);

  irq_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_size(bus_size),
    .status(status_q), .enable(enable_q), .mask(mask_q),
    .stat_clr(stat_clr), .ena_set(ena_set), .ena_clr(ena_clr),
    .msk_set(msk_set), .msk_clr(msk_clr), .rdata(bus_rdata)
  );

  irq_status_reg #(.W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .evt(evt_ext), .mask(mask_q),
    .clr_we(stat_clr), .wdata(bus_wdata), .status_q(status_q)
  );

  irq_setclr_reg #(.W(DATA_W)) u_enable (
    .clk(clk), .rst(rst), .set_we(ena_set), .clr_we(ena_clr),
    .wdata(bus_wdata), .q(enable_q)
  );

  irq_setclr_reg #(.W(DATA_W)) u_mask (
    .clk(clk), .rst(rst), .set_we(msk_set), .clr_we(msk_clr),
    .wdata(bus_wdata), .q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_q & enable_q);
  end

  initial begin
    if (NUM_SRC > DATA_W) $error("NUM_SRC must not exceed DATA_W");
    if (ADDR_W < 5)       $error("ADDR_W too small for the register map");
  end

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_o == |($past(status_q) & $past(enable_q))));

  // R1
  irq_reset_chk: assert property (@(posedge clk) rst |=> !irq_o);

endmodule

// File: tb/irq_setclr_ctrl_tb.sv
module irq_setclr_ctrl_tb;

  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] evt_i = '0;
  logic        irq_o;

  logic [31:0] st = '0, en = '0, mk = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_setclr_ctrl #(.NUM_SRC(NS), .ADDR_W(8), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a, logic [1:0] sz);
    logic [31:0] raw;
    logic [31:0] m;
    case (a >> 2)
      0:       raw = st;
      1, 2:    raw = en;
      3, 4:    raw = mk;
      default: raw = '0;
    endcase
    m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (raw >> (8 * a[1:0])) & m;
  endfunction

  task automatic model_edge(bit we, logic [7:0] a, logic [31:0] d, logic [NS-1:0] ev);
    logic [31:0] acc;
    acc = 32'(ev) & ~mk;
    if (we && (a >> 2) == 0) st = (st & ~d) | acc;
    else                     st = st | acc;
    if (we) begin
      case (a >> 2)
        1: en = en | d;
        2: en = en & ~d;
        3: mk = mk | d;
        4: mk = mk & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [NS-1:0] ev = '0);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(posedge clk);
    model_edge(1'b1, a, d, ev);
    @(negedge clk);
    bus_we = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(logic [NS-1:0] ev);
    evt_i = ev;
    @(posedge clk);
    model_edge(1'b0, 8'h0, 32'h0, ev);
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] sz, string tag);
    bus_re = 1'b1; bus_addr = a; bus_size = sz;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    chk(tag, bus_rdata, model_read(a, sz));
  endtask

  task automatic chk_irq(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {31'b0, irq_o}, {31'b0, |(st & en)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    for (int a = 0; a < 5; a++) rd(8'(a * 4), 2'd2, "R1 reg after reset");

    // R3 R4 R8 enable set/clear sweep
    for (int i = 0; i < 64; i++) begin
      wr(8'h04, i * 32'h9E37_79B1);
      rd(8'h04, 2'd2, "R3 enable set readback");
      rd(8'h08, 2'd2, "R8 enable via clear addr");
      wr(8'h08, i * 32'h7F4A_7C15);
      rd(8'h08, 2'd2, "R4 enable clear");
    end

    // R5 mask set/clear sweep
    for (int i = 0; i < 64; i++) begin
      wr(8'h0C, i * 32'h85EB_CA6B);
      rd(8'h0C, 2'd2, "R5 mask set");
      wr(8'h10, i * 32'hC2B2_AE35);
      rd(8'h10, 2'd2, "R5 mask clear");
    end

    // R6 R7 sweep over masks, enables and events
    for (int i = 0; i < 256; i++) begin
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h0C, (i * 32'h2545_F491) ^ 32'h5A5A);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h04, i * 32'h0001_3579);
      wr(8'h00, 32'hFFFF_FFFF);
      pulse(NS'(i * 16'h9D2B) ^ NS'(i));
      rd(8'h00, 2'd2, "R6 masked latching");
      chk_irq("R7 irq level");
    end

    // R2 write-one-to-clear
    wr(8'h10, 32'hFFFF_FFFF);
    pulse(16'hFFFF);
    wr(8'h00, 32'h0000_3C96);
    rd(8'h00, 2'd2, "R2 w1c leaves other bits");
    wr(8'h08, 32'hFFFF_FFFF);
    chk_irq("R7 enable gates irq, status kept");

    // R9 event beats clear
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_FFFF, 16'h00F0);
    rd(8'h00, 2'd2, "R9 event wins");

    // R6 masked event is lost
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0000_0001);
    pulse(16'h0001);
    wr(8'h10, 32'h0000_0001);
    rd(8'h00, 2'd2, "R6 masked event lost");

    // R10 narrow read lanes
    pulse(16'hA5C3);
    wr(8'h04, 32'h1234_5678);
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 4; sz++) begin
        rd(8'(4 + off), 2'(sz), "R10 enable lanes");
        rd(8'(off), 2'(sz), "R10 status lanes");
      end

    // R11 unmapped address
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h20, 2'd2, "R11 unmapped read");
    for (int a = 0; a < 5; a++) rd(8'(a * 4), 2'd2, "R11 regs untouched");
    chk_irq("R7 final irq");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule